// File: doc/BRIEF.md
# Framed Serial Register Access Engine

This block is a serial-bus master that carries single register operations to a four-channel output converter. A host presents one operation at a time: a direction bit (write or read), a 5-bit register address and, for a write, a 16-bit value. The engine builds 24-bit frames, shifts them out most significant bit first on a clock it divides down from the system clock, and frames each one with an active-low chip select. When the operation completes, it raises a one-cycle completion pulse. For a read, it also presents the 16-bit answer.

A write uses one frame. A read uses two frames. The first is a flagged request that names the register. Chip select is then released for a guaranteed idle stretch. The second frame carries a fixed filler code, and the answer arrives on the slave output line during that frame. The engine does not decode register addresses. The host picks them, and the converter uses different address sets for the write and read directions.

Top module: `spi_reg_engine`

## Requirements
- R1: Every chip-select-low window contains exactly 24 rising serial-clock edges, with the frame sent most significant bit first.
- R2: A write frame is {3'b000, addr[4:0], data[15:0]}: bit 23 clear, bits 22:21 zero, address in bits 20:16, value in bits 15:0.
- R3: A read sends two frames in order: first {1'b1, 2'b00, addr[4:0], 16'h0000}, then the filler 24'h1CE000.
- R4: Between the two frames of a read, chip select stays high for at least CS_GAP_SCLK serial-clock periods, that is, CS_GAP_SCLK*2*HALF_DIV system cycles.
- R5: rd_data takes the last 16 bits received on miso during the filler frame (first received bit is the most significant). It changes only in the cycle the read's done pulse appears. A write leaves it unchanged.
- R6: The serial clock idles low whenever chip select is high. miso is sampled when the serial clock rises. mosi changes only while the serial clock is low, so it is stable throughout every high phase.
- R7: busy rises in the cycle after a request is accepted (req_valid high while busy low). A request presented while busy is high is ignored: no frame is sent, no done pulse follows and no register is touched.
- R8: done is high for exactly one cycle, in the same cycle busy falls. The accept edge is edge 0. For a write, done appears after edge 2+2*24*HALF_DIV. For a read, done appears after edge 4+4*24*HALF_DIV+CS_GAP_SCLK*2*HALF_DIV.
- R9: During and after reset: cs_n=1, sclk=0, mosi=0, busy=0, done=0, rd_data=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request, taken when busy is low |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 5 | Register address |
| req_data | input | 16 | Write value (ignored for reads) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Readback value of the last read |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |

## Verification
Writes are driven with all-zero, all-one and mixed values at the lowest, highest and mid-range addresses. This separates bit ordering errors from field placement errors. Reads go to both freshly written and untouched registers, so a returned value can only match if the filler frame's receive bits were captured, not echoed from the request. A request issued in the very cycle of a done pulse confirms that the engine re-arms at once. A second request held high through a busy window must produce no extra frame and must leave its target register unchanged.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam int FRAME_W     = 24;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 16;
  localparam int RD_FLAG_POS = FRAME_W - 1;
  localparam int ADDR_POS    = DATA_W;

  localparam logic [FRAME_W-1:0] FILLER_FRAME = 24'h1CE000;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FIRST,
    SQ_GAP,
    SQ_SECOND
  } seq_state_e;

  function automatic logic [FRAME_W-1:0] pack_write(
    input logic [ADDR_W-1:0] a,
    input logic [DATA_W-1:0] d
  );
    logic [FRAME_W-1:0] f;
    f = '0;
    f[ADDR_POS +: ADDR_W] = a;
    f[DATA_W-1:0]         = d;
    return f;
  endfunction

  function automatic logic [FRAME_W-1:0] pack_read(input logic [ADDR_W-1:0] a);
    logic [FRAME_W-1:0] f;
    f = '0;
    f[RD_FLAG_POS]        = 1'b1;
    f[ADDR_POS +: ADDR_W] = a;
    return f;
  endfunction

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!en || cnt == LAST) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter #(
  parameter int FW   = 24,
  parameter int RX_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] frame_in,
  input  logic          tick,
  input  logic          miso,
  output logic          active,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n,
  output logic [RX_W-1:0] rx_word,
  output logic          frame_done
);
  localparam int BW = $clog2(FW);
  localparam logic [BW-1:0] LAST_BIT = BW'(FW - 1);

  logic [FW-2:0] shreg;
  logic [BW-1:0] bitcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      sclk       <= 1'b0;
      mosi       <= 1'b0;
      cs_n       <= 1'b1;
      shreg      <= '0;
      bitcnt     <= '0;
      rx_word    <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        cs_n    <= 1'b0;
        sclk    <= 1'b0;
        mosi    <= frame_in[FW-1];
        shreg   <= frame_in[FW-2:0];
        bitcnt  <= '0;
        rx_word <= '0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_word <= {rx_word[RX_W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitcnt == LAST_BIT) begin
            active     <= 1'b0;
            cs_n       <= 1'b1;
            mosi       <= 1'b0;
            frame_done <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
            mosi   <= shreg[FW-2];
            shreg  <= {shreg[FW-3:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_op_sequencer.sv
module spi_op_sequencer
  import spi_reg_pkg::*;
#(
  parameter int GAP_CYC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_read,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_data,
  input  logic               frame_done,
  input  logic [DATA_W-1:0]  rx_word,
  output logic               start,
  output logic [FRAME_W-1:0] frame_out,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               accept,
  output logic               second_frame
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  seq_state_e state;
  logic       is_rd;
  logic [GW-1:0] gcnt;

  assign busy         = (state != SQ_IDLE);
  assign accept       = (state == SQ_IDLE) && req_valid;
  assign second_frame = (state == SQ_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      is_rd     <= 1'b0;
      gcnt      <= '0;
      start     <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
      frame_out <= '0;
    end else begin
      start <= 1'b0;
      done  <= 1'b0;
      unique case (state)
        SQ_IDLE: if (req_valid) begin
          is_rd     <= req_read;
          frame_out <= req_read ? pack_read(req_addr) : pack_write(req_addr, req_data);
          start     <= 1'b1;
          state     <= SQ_FIRST;
        end
        SQ_FIRST: if (frame_done) begin
          if (is_rd) begin
            state     <= SQ_GAP;
            gcnt      <= '0;
            frame_out <= FILLER_FRAME;
          end else begin
            state <= SQ_IDLE;
            done  <= 1'b1;
          end
        end
        SQ_GAP: begin
          if (gcnt == GAP_LAST) begin
            start <= 1'b1;
            state <= SQ_SECOND;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        SQ_SECOND: if (frame_done) begin
          rd_data <= rx_word;
          done    <= 1'b1;
          state   <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_engine.sv
module spi_reg_engine
  import spi_reg_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int CS_GAP_SCLK = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int GAP_CYC = CS_GAP_SCLK * 2 * HALF_DIV;

  logic               start;
  logic [FRAME_W-1:0] frame_bus;
  logic               frame_done;
  logic [DATA_W-1:0]  rx_word;
  logic               shift_active;
  logic               half_tick;
  logic               accept;
  logic               second_frame;

  spi_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (shift_active),
    .tick (half_tick)
  );

  spi_frame_shifter #(.FW(FRAME_W), .RX_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .frame_in  (frame_bus),
    .tick      (half_tick),
    .miso      (miso),
    .active    (shift_active),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .rx_word   (rx_word),
    .frame_done(frame_done)
  );

  spi_op_sequencer #(.GAP_CYC(GAP_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_read    (req_read),
    .req_addr    (req_addr),
    .req_data    (req_data),
    .frame_done  (frame_done),
    .rx_word     (rx_word),
    .start       (start),
    .frame_out   (frame_bus),
    .busy        (busy),
    .done        (done),
    .rd_data     (rd_data),
    .accept      (accept),
    .second_frame(second_frame)
  );
endmodule

// File: rtl/spi_reg_engine_chk.sv
module spi_reg_engine_chk #(
  parameter int HALF_DIV    = 2,
  parameter int CS_GAP_SCLK = 2
) (
  input logic clk,
  input logic rst_n,
  input logic accept,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic second_frame
);
  localparam int GAP_CYC = CS_GAP_SCLK * 2 * HALF_DIV;
  localparam int NBITS   = 24;

  logic [7:0]  rise_cnt;
  logic [15:0] hi_cnt;
  logic        sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      hi_cnt   <= '0;
      sclk_d   <= 1'b0;
    end else begin
      sclk_d   <= sclk;
      rise_cnt <= cs_n ? 8'd0 : rise_cnt + {7'd0, (sclk && !sclk_d)};
      hi_cnt   <= !cs_n ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1);
    end
  end

  a_r1_frame_bits: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rise_cnt == 8'(NBITS)));

  a_r4_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && second_frame) |-> (hi_cnt >= 16'(GAP_CYC)));

  a_r6_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r6_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind spi_reg_engine spi_reg_engine_chk #(
  .HALF_DIV   (HALF_DIV),
  .CS_GAP_SCLK(CS_GAP_SCLK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .busy        (busy),
  .done        (done),
  .sclk        (sclk),
  .mosi        (mosi),
  .cs_n        (cs_n),
  .second_frame(second_frame)
);

// File: tb/tb_spi_reg_engine.sv
module tb_spi_reg_engine;
  localparam int HALF_DIV    = 2;
  localparam int CS_GAP_SCLK = 2;
  localparam int GAP_CYC     = CS_GAP_SCLK * 2 * HALF_DIV;
  localparam int LAT_WR      = 2 + 2 * 24 * HALF_DIV;
  localparam int LAT_RD      = 4 + 4 * 24 * HALF_DIV + GAP_CYC;
  localparam logic [23:0] FILLER = 24'h1CE000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic        busy, done, sclk, mosi, cs_n;
  logic        miso = 1'b0;
  logic [15:0] rd_data;

  spi_reg_engine #(.HALF_DIV(HALF_DIV), .CS_GAP_SCLK(CS_GAP_SCLK)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int vectors = 0, fails = 0;

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] preload(input int i);
    return 16'h1000 + 16'(i) * 16'h0111;
  endfunction

  // reference model of the host-side handshake
  logic        m_busy = 1'b0, m_done = 1'b0, m_isrd = 1'b0;
  int          m_cnt = 0, m_lat = 0;
  logic [15:0] m_rd = '0, m_pend = '0;
  logic [15:0] mirror [32];
  logic [23:0] exp_q [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_rd = '0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_lat) begin
          m_busy = 1'b0; m_done = 1'b1;
          if (m_isrd) m_rd = m_pend;
        end
      end else if (req_valid) begin
        m_busy = 1'b1; m_cnt = 0; m_isrd = req_read;
        if (req_read) begin
          m_lat  = LAT_RD;
          m_pend = mirror[req_addr];
          exp_q.push_back({1'b1, 2'b00, req_addr, 16'h0000});
          exp_q.push_back(FILLER);
        end else begin
          m_lat = LAT_WR;
          mirror[req_addr] = req_data;
          exp_q.push_back({3'b000, req_addr, req_data});
        end
      end
    end
  end

  // per-cycle comparison
  logic p_sclk = 1'b0, p_mosi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 busy", {23'd0, busy}, {23'd0, m_busy});
      chk("R8 done", {23'd0, done}, {23'd0, m_done});
      chk("R5 rd_data", {8'd0, rd_data}, {8'd0, m_rd});
      if (cs_n) chk("R6 sclk idle", {23'd0, sclk}, 24'd0);
      if (sclk && p_sclk) chk("R6 mosi hold", {23'd0, mosi}, {23'd0, p_mosi});
    end
    p_sclk = sclk; p_mosi = mosi;
  end

  // behavioural converter on the serial side
  logic [15:0] sregs [32];
  logic [23:0] s_tx = '0, s_rx = '0, e;
  int          s_bits = 0;
  logic        s_pend = 1'b0, last_req = 1'b0;
  logic [4:0]  s_paddr = '0;
  realtime     t_rise = 0;

  always @(negedge cs_n) begin
    s_bits = 0; s_rx = '0;
    s_tx = s_pend ? {3'b000, s_paddr, sregs[s_paddr]} : 24'hC3A55A;
    miso = s_tx[23];
    if (last_req) begin
      vectors++;
      if ($realtime - t_rise < GAP_CYC * 4.0) begin
        fails++;
        $display("FAIL R4 cs gap actual=%0t expected>=%0d ns", $realtime - t_rise, GAP_CYC * 4);
      end
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    s_tx = {s_tx[22:0], 1'b0};
    miso = s_tx[23];
  end

  always @(posedge sclk) begin
    s_rx = {s_rx[22:0], mosi};
    s_bits++;
  end

  always @(posedge cs_n) if (rst_n) begin
    chk("R1 bits per frame", 24'(s_bits), 24'd24);
    if (exp_q.size() == 0) begin
      vectors++; fails++;
      $display("FAIL R7 unexpected frame actual=%h expected=none", s_rx);
    end else begin
      e = exp_q.pop_front();
      chk((e[23] || e == FILLER) ? "R3 read frame" : "R2 write frame", s_rx, e);
    end
    last_req = s_rx[23];
    t_rise   = $realtime;
    if (s_rx[23]) begin
      s_pend = 1'b1; s_paddr = s_rx[20:16];
    end else begin
      s_pend = 1'b0;
      if (s_rx != FILLER) sregs[s_rx[20:16]] = s_rx[15:0];
    end
  end

  task automatic issue(input logic rd, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done;
    while (!done) @(negedge clk);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    issue(1'b0, a, d);
    wait_done();
  endtask

  task automatic do_read(input logic [4:0] a, input logic [15:0] expv);
    issue(1'b1, a, 16'h0000);
    wait_done();
    chk("R5 readback", {8'd0, rd_data}, {8'd0, expv});
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      sregs[i]  = preload(i);
      mirror[i] = preload(i);
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 cs_n", {23'd0, cs_n}, 24'd1);
    chk("R9 sclk", {23'd0, sclk}, 24'd0);
    chk("R9 mosi", {23'd0, mosi}, 24'd0);
    chk("R9 busy", {23'd0, busy}, 24'd0);
    chk("R9 done", {23'd0, done}, 24'd0);
    chk("R9 rd_data", {8'd0, rd_data}, 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", {20'd0, cs_n, sclk, busy, done}, 24'h8);

    // R2 writes at field extremes
    do_write(5'd0,  16'h1234);
    do_write(5'd31, 16'hFFFF);
    do_write(5'd8,  16'h0000);
    do_write(5'd28, 16'h8001);
    chk("R5 rd_data held after write", {8'd0, rd_data}, 24'd0);

    // R3 / R5 reads
    do_read(5'd0,  16'h1234);
    do_read(5'd31, 16'hFFFF);
    do_read(5'd8,  16'h0000);
    do_read(5'd26, preload(26));
    do_write(5'd3, 16'hC0DE);
    chk("R5 rd_data held after write", {8'd0, rd_data}, {8'd0, preload(26)});

    // R8 back-to-back: request in the done cycle
    issue(1'b0, 5'd2, 16'h5A5A);
    wait_done();
    req_valid = 1'b1; req_read = 1'b1; req_addr = 5'd2; req_data = '0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 accepted in done cycle", {23'd0, busy}, 24'd1);
    wait_done();
    chk("R5 back-to-back read", {8'd0, rd_data}, 24'h005A5A);

    // R7 request while busy is ignored
    issue(1'b0, 5'd4, 16'hAAAA);
    req_valid = 1'b1; req_read = 1'b0; req_addr = 5'd5; req_data = 16'hBEEF;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    do_read(5'd5, preload(5));
    do_read(5'd4, 16'hAAAA);

    repeat (20) @(negedge clk);
    chk("R7 no pending frames", 24'(exp_q.size()), 24'd0);
    summary();
  end
endmodule